// File: doc/BRIEF.md
# Synthesizer Control-Byte Mode Decoder

This block sits behind the register interface of a frequency synthesizer and turns the fields of its control byte into the controls the rest of the synthesizer needs. A control-byte write strobe latches a 3-bit operating-mode field and a 3-bit reference-select field. From the mode field the block derives a select for the auxiliary clock output pin, the charge-pump controls, a test-mode indication and a loop-bandwidth-control enable. The mode field can also toggle that enable.

From the reference-select field the block looks up a reference divide ratio of 1, 2 or 4. It then divides the crystal clock, which is the block clock, into a comparison-clock enable. A change of the reference setting makes the two divider data bytes stale. A small state machine tracks their rewrite and raises a pending flag until both data-byte strobes have been seen.

The state machine has four states. IDLE means nothing is pending. WAIT_BOTH means neither data byte has been seen yet. WAIT_DB2 means byte 1 has been seen. WAIT_DB1 means byte 2 has been seen.
- Transition CHANGE: a valid control write with a new reference code enters WAIT_BOTH from any state. It takes priority over data strobes in the same cycle.
- Transition GOT1: from WAIT_BOTH, the byte-1 strobe alone leads to WAIT_DB2.
- Transition GOT2: from WAIT_BOTH, the byte-2 strobe alone leads to WAIT_DB1.
- Transition DONE: both strobes together in WAIT_BOTH, byte 1 in WAIT_DB1, or byte 2 in WAIT_DB2 return the machine to IDLE.
- Data strobes in IDLE have no effect.

Top module: `synth_ctrl_decoder`

## Requirements
- R1: After reset the mode field holds 110. The auxiliary select is 1 (crystal), cp_sink is 1, and cp_off, cp_source, test_mode and bw_ctl_en are 0. The reference code is 000, div_ratio is 2, and rewrite_pend and ref_err are 0.
- R2: aux_sel encodes the auxiliary pin source as 0 = off, 1 = crystal, 2 = half main-divider, 3 = comparison clock. Mode 000 and 111 give 0. Modes 001, 011 and 110 give 1. Modes 010 and 101 give 2. Mode 100 gives 3.
- R3: cp_off is 1 only in mode 010, cp_sink only in mode 110, and cp_source only in mode 111. test_mode is 1 only in modes 100 and 101.
- R4: Each control write that carries mode 011 inverts bw_ctl_en, so two such writes in a row restore it. Writes with any other mode leave it unchanged.
- R5: Reference codes map to div_ratio as follows: 000 gives 2, 011 gives 4, and 001, 010 and 100 give 1.
- R6: A write with reference code 101, 110 or 111 keeps the previous reference code and ratio and sets ref_err. ref_err stays set until the next write with a valid reference code.
- R7: cmp_en is 1 when the divider count is 0. The count wraps at ratio-1 and restarts at 0 on a valid write that changes the reference code. Ratio 1 gives cmp_en every cycle, ratio 2 gives 1,0 alternating, and ratio 4 gives one cycle in four.
- R8: rewrite_pend rises on a valid write that changes the reference code. It falls only after both db1_wr and db2_wr have been seen, in either order or together. Strobes with nothing pending have no effect.
- R9: All outputs reflect a control write from the clock edge that samples ctl_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control-byte write strobe |
| ctl_mode | input | 3 | Operating-mode field |
| ctl_ref | input | 3 | Reference-select field |
| db1_wr | input | 1 | Divider data byte 1 write strobe |
| db2_wr | input | 1 | Divider data byte 2 write strobe |
| aux_sel | output | 2 | Auxiliary pin source select |
| cp_off | output | 1 | Charge pump disabled |
| cp_sink | output | 1 | Charge pump forced to sink |
| cp_source | output | 1 | Charge pump forced to source |
| test_mode | output | 1 | Test mode active |
| bw_ctl_en | output | 1 | Loop-bandwidth control enable |
| div_ratio | output | 3 | Reference divide ratio in force |
| cmp_en | output | 1 | Comparison-clock enable |
| ref_err | output | 1 | Sticky reserved-reference flag |
| rewrite_pend | output | 1 | Data bytes must be rewritten |

## Verification
Every mode code is written from both bandwidth-enable states. Back-to-back 011 writes separate a real toggle from a level set. Reference codes are walked through all eight values, so reserved writes are told apart from valid ones and a same-code rewrite is told apart from a change. Data strobes arrive in both orders, together, while idle, and colliding with a new change, which exercises each state-machine transition. Random writes and strobes then run against a bench model of the divider phase.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;
    localparam int MODE_W  = 3;
    localparam int REF_W   = 3;
    localparam int RATIO_W = 3;

    typedef enum logic [1:0] {
        AUX_OFF  = 2'd0,
        AUX_XTAL = 2'd1,
        AUX_HALF = 2'd2,
        AUX_COMP = 2'd3
    } aux_src_e;

    typedef enum logic [1:0] {
        RW_IDLE,
        RW_WAIT_BOTH,
        RW_WAIT_DB1,
        RW_WAIT_DB2
    } rw_state_e;

    localparam logic [MODE_W-1:0] MODE_TOGGLE = 3'b011;
    localparam logic [MODE_W-1:0] MODE_RESET  = 3'b110;
    localparam logic [REF_W-1:0]  REF_RESET   = 3'b000;

    // 0 marks a reserved code
    function automatic logic [RATIO_W-1:0] ref_ratio(input logic [REF_W-1:0] code);
        case (code)
            3'b000:  return 3'd2;
            3'b001:  return 3'd1;
            3'b010:  return 3'd1;
            3'b011:  return 3'd4;
            3'b100:  return 3'd1;
            default: return 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/mode_decode.sv
module mode_decode
    import synth_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [MODE_W-1:0] mode_in,
    output aux_src_e          aux_sel,
    output logic              cp_off,
    output logic              cp_sink,
    output logic              cp_source,
    output logic              test_mode,
    output logic              bw_en
);
    logic [MODE_W-1:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET;
            bw_en  <= 1'b0;
        end else if (wr) begin
            mode_q <= mode_in;
            if (mode_in == MODE_TOGGLE)
                bw_en <= ~bw_en;
        end
    end

    always_comb begin
        aux_sel   = AUX_OFF;
        cp_off    = 1'b0;
        cp_sink   = 1'b0;
        cp_source = 1'b0;
        test_mode = 1'b0;
        unique case (mode_q)
            3'b000: aux_sel = AUX_OFF;
            3'b001: aux_sel = AUX_XTAL;
            3'b010: begin aux_sel = AUX_HALF; cp_off = 1'b1; end
            3'b011: aux_sel = AUX_XTAL;
            3'b100: begin aux_sel = AUX_COMP; test_mode = 1'b1; end
            3'b101: begin aux_sel = AUX_HALF; test_mode = 1'b1; end
            3'b110: begin aux_sel = AUX_XTAL; cp_sink = 1'b1; end
            3'b111: begin aux_sel = AUX_OFF;  cp_source = 1'b1; end
        endcase
    end

    assert_bw_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && mode_in == MODE_TOGGLE) |=> (bw_en != $past(bw_en)));
    assert_bw_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && mode_in == MODE_TOGGLE) |=> $stable(bw_en));
    assert_cp_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cp_off, cp_sink, cp_source}));
endmodule

// File: rtl/ref_divider.sv
module ref_divider
    import synth_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [REF_W-1:0]   ref_in,
    output logic [RATIO_W-1:0] ratio,
    output logic               ref_changed,
    output logic               err,
    output logic               cmp_en
);
    localparam int CNT_W = RATIO_W - 1;

    logic [REF_W-1:0]   ref_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [RATIO_W-1:0] new_ratio;
    logic               valid_wr;
    logic               wrap;

    assign new_ratio   = ref_ratio(ref_in);
    assign valid_wr    = wr && (new_ratio != '0);
    assign ref_changed = valid_wr && (ref_in != ref_q);
    assign ratio       = ref_ratio(ref_q);
    assign wrap        = ({1'b0, cnt_q} == ratio - 3'd1);
    assign cmp_en      = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= REF_RESET;
            err   <= 1'b0;
            cnt_q <= '0;
        end else begin
            if (wr)
                err <= !valid_wr;
            if (ref_changed) begin
                ref_q <= ref_in;
                cnt_q <= '0;
            end else if (wrap) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_reserved_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && new_ratio == '0) |=> ($stable(ratio) && err));
    assert_div4_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio == 3'd4 && cmp_en && !ref_changed) |=> !cmp_en);
    assert_div1_every_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio == 3'd1 && !ref_changed) |=> cmp_en);
endmodule

// File: rtl/rewrite_fsm.sv
module rewrite_fsm
    import synth_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_changed,
    input  logic db1,
    input  logic db2,
    output logic pend
);
    rw_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RW_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (ref_changed) begin
            state_d = RW_WAIT_BOTH;
        end else begin
            unique case (state_q)
                RW_IDLE:      state_d = RW_IDLE;
                RW_WAIT_BOTH: begin
                    if (db1 && db2) state_d = RW_IDLE;
                    else if (db1)   state_d = RW_WAIT_DB2;
                    else if (db2)   state_d = RW_WAIT_DB1;
                end
                RW_WAIT_DB1:  if (db1) state_d = RW_IDLE;
                RW_WAIT_DB2:  if (db2) state_d = RW_IDLE;
            endcase
        end
    end

    assign pend = (state_q != RW_IDLE);

    assert_pend_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_changed |=> pend);
    assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !db1 && !db2) |=> pend);
    assert_idle_stay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !ref_changed) |=> !pend);
endmodule

// File: rtl/synth_ctrl_decoder.sv
module synth_ctrl_decoder
    import synth_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [2:0] ctl_mode,
    input  logic [2:0] ctl_ref,
    input  logic       db1_wr,
    input  logic       db2_wr,
    output logic [1:0] aux_sel,
    output logic       cp_off,
    output logic       cp_sink,
    output logic       cp_source,
    output logic       test_mode,
    output logic       bw_ctl_en,
    output logic [2:0] div_ratio,
    output logic       cmp_en,
    output logic       ref_err,
    output logic       rewrite_pend
);
    aux_src_e aux_src;
    logic     ref_changed;

    mode_decode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (ctl_wr),
        .mode_in   (ctl_mode),
        .aux_sel   (aux_src),
        .cp_off    (cp_off),
        .cp_sink   (cp_sink),
        .cp_source (cp_source),
        .test_mode (test_mode),
        .bw_en     (bw_ctl_en)
    );

    ref_divider u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (ctl_wr),
        .ref_in      (ctl_ref),
        .ratio       (div_ratio),
        .ref_changed (ref_changed),
        .err         (ref_err),
        .cmp_en      (cmp_en)
    );

    rewrite_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_changed (ref_changed),
        .db1         (db1_wr),
        .db2         (db2_wr),
        .pend        (rewrite_pend)
    );

    assign aux_sel = aux_src;

    assert_no_change_no_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr && !rewrite_pend) |=> !rewrite_pend);
endmodule

// File: tb/test_synth_ctrl_decoder.sv
module test_synth_ctrl_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [2:0] ctl_mode = 3'd0;
    logic [2:0] ctl_ref = 3'd0;
    logic       db1_wr = 1'b0;
    logic       db2_wr = 1'b0;
    logic [1:0] aux_sel;
    logic       cp_off, cp_sink, cp_source, test_mode, bw_ctl_en;
    logic [2:0] div_ratio;
    logic       cmp_en, ref_err, rewrite_pend;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench reference model
    logic [2:0] m_mode = 3'b110;
    logic       m_bw = 1'b0;
    logic [2:0] m_ref = 3'b000;
    logic       m_err = 1'b0;
    logic       m_pend = 1'b0;
    logic       m_s1 = 1'b0;
    logic       m_s2 = 1'b0;
    int         m_cnt = 0;

    synth_ctrl_decoder i_synth_ctrl_decoder (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_mode(ctl_mode),
        .ctl_ref(ctl_ref), .db1_wr(db1_wr), .db2_wr(db2_wr),
        .aux_sel(aux_sel), .cp_off(cp_off), .cp_sink(cp_sink),
        .cp_source(cp_source), .test_mode(test_mode), .bw_ctl_en(bw_ctl_en),
        .div_ratio(div_ratio), .cmp_en(cmp_en), .ref_err(ref_err),
        .rewrite_pend(rewrite_pend)
    );

    always #5 clk = ~clk;

    function automatic int f_ratio(input logic [2:0] r);
        case (r)
            3'd0: return 2;
            3'd3: return 4;
            3'd1, 3'd2, 3'd4: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [1:0] f_aux(input logic [2:0] m);
        case (m)
            3'd1, 3'd3, 3'd6: return 2'd1;
            3'd2, 3'd5:       return 2'd2;
            3'd4:             return 2'd3;
            default:          return 2'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            logic restart;
            restart = 1'b0;
            if (ctl_wr) begin
                if (ctl_mode == 3'b011) m_bw <= ~m_bw;
                m_mode <= ctl_mode;
                if (f_ratio(ctl_ref) != 0) begin
                    m_err <= 1'b0;
                    if (ctl_ref != m_ref) begin
                        restart = 1'b1;
                        m_ref  <= ctl_ref;
                        m_pend <= 1'b1;
                        m_s1   <= 1'b0;
                        m_s2   <= 1'b0;
                        m_cnt  <= 0;
                    end
                end else begin
                    m_err <= 1'b1;
                end
            end
            if (!restart) begin
                m_cnt <= (m_cnt == f_ratio(m_ref) - 1) ? 0 : m_cnt + 1;
                if (m_pend) begin
                    if ((m_s1 | db1_wr) && (m_s2 | db2_wr)) begin
                        m_pend <= 1'b0; m_s1 <= 1'b0; m_s2 <= 1'b0;
                    end else begin
                        m_s1 <= m_s1 | db1_wr;
                        m_s2 <= m_s2 | db2_wr;
                    end
                end
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // called at negedge, away from the active edge
    task automatic check_all(input string req);
        check(req, "aux_sel",   aux_sel,   f_aux(m_mode));
        check(req, "cp_off",    cp_off,    m_mode == 3'd2);
        check(req, "cp_sink",   cp_sink,   m_mode == 3'd6);
        check(req, "cp_source", cp_source, m_mode == 3'd7);
        check(req, "test_mode", test_mode, m_mode == 3'd4 || m_mode == 3'd5);
        check(req, "bw_ctl_en", bw_ctl_en, m_bw);
        check(req, "div_ratio", div_ratio, f_ratio(m_ref));
        check(req, "cmp_en",    cmp_en,    m_cnt == 0);
        check(req, "ref_err",   ref_err,   m_err);
        check(req, "rewrite_pend", rewrite_pend, m_pend);
    endtask

    task automatic cyc(input logic w, input logic [2:0] m, input logic [2:0] r,
                       input logic d1, input logic d2, input string req);
        ctl_wr = w; ctl_mode = m; ctl_ref = r; db1_wr = d1; db2_wr = d2;
        @(negedge clk);
        ctl_wr = 1'b0; db1_wr = 1'b0; db2_wr = 1'b0;
        check_all(req);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 3'd0, 1'b0, 1'b0, req);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values against literals
        check("R1", "aux_sel", aux_sel, 1);
        check("R1", "cp_sink", cp_sink, 1);
        check("R1", "bw_ctl_en", bw_ctl_en, 0);
        check("R1", "div_ratio", div_ratio, 2);
        check("R1", "rewrite_pend", rewrite_pend, 0);
        check_all("R1");
        // R7 divide-by-2 from reset
        idle(4, "R7");
        // R2/R3 every mode code; R9 update after one edge
        for (int m = 0; m < 8; m++) cyc(1'b1, 3'(m), m_ref, 1'b0, 1'b0, "R2_R3_R9");
        // R4 back-to-back toggles
        cyc(1'b1, 3'b011, m_ref, 1'b0, 1'b0, "R4");
        check("R4", "bw after one 011", bw_ctl_en, 0);
        cyc(1'b1, 3'b011, m_ref, 1'b0, 1'b0, "R4");
        check("R4", "bw after two 011", bw_ctl_en, 1);
        cyc(1'b1, 3'b001, m_ref, 1'b0, 1'b0, "R4");
        check("R4", "bw held by other mode", bw_ctl_en, 1);
        // R5/R7/R8 ratio 4, strobes in order db2 then db1
        cyc(1'b1, 3'b001, 3'b011, 1'b0, 1'b0, "R5_R8");
        check("R5", "ratio code 011", div_ratio, 4);
        idle(6, "R7");
        cyc(1'b0, 3'd0, 3'd0, 1'b0, 1'b1, "R8");
        check("R8", "pend after db2 only", rewrite_pend, 1);
        cyc(1'b0, 3'd0, 3'd0, 1'b1, 1'b0, "R8");
        check("R8", "pend after both", rewrite_pend, 0);
        // R8 strobes while idle are ignored
        cyc(1'b0, 3'd0, 3'd0, 1'b1, 1'b1, "R8");
        // R6 reserved codes
        for (int r = 5; r < 8; r++) begin
            cyc(1'b1, 3'b001, 3'(r), 1'b0, 1'b0, "R6");
            check("R6", "ratio kept", div_ratio, 4);
            check("R6", "err set", ref_err, 1);
        end
        cyc(1'b1, 3'b001, 3'b011, 1'b0, 1'b0, "R6");
        check("R6", "err cleared by valid same code", ref_err, 0);
        check("R8", "no pend on same code", rewrite_pend, 0);
        // R8 both strobes together, and change colliding with strobes
        cyc(1'b1, 3'b001, 3'b100, 1'b0, 1'b0, "R5_R8");
        cyc(1'b1, 3'b001, 3'b001, 1'b1, 1'b1, "R8");
        check("R8", "change beats strobes", rewrite_pend, 1);
        cyc(1'b0, 3'd0, 3'd0, 1'b1, 1'b1, "R8");
        check("R8", "together clears", rewrite_pend, 0);
        // R5 remaining codes
        cyc(1'b1, 3'b001, 3'b010, 1'b1, 1'b0, "R5");
        cyc(1'b1, 3'b001, 3'b000, 1'b0, 1'b0, "R5_R7");
        idle(5, "R7");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int p;
            logic w;
            p = int'($urandom_range(0, 99));
            w = (p < 25);
            cyc(w, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0), "R2_R4_R6_R7_R8");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule